// File: doc/BRIEF.md
# VLAN-Aware Forwarding Database Engine

This block is the address engine of an 11-port switch. For every frame presented on its request inputs, it does two things. It learns the source address, and it looks up the destination address. It then returns one egress bit per port. Configuration writes fill two tables. The per-VLAN table holds a learning mode, a filter ID and a member mask. The per-port table holds a 3-bit learning-domain ID and a learning enable.

The mode of each VLAN decides how the table key is built. A shared-learning VLAN keys its entries by filter ID and MAC, so VLANs with the same filter ID see the same addresses. An independent-learning VLAN keys its entries by VID, MAC and the learning-domain ID. The same address on the same VLAN can therefore live on several ports, as long as those ports sit in different domains.

Frames injected by the CPU port carry a tag with these fields:
- a domain override, which changes only what is learned;
- a learn-disable bit;
- an ALLOW bit with an allowance mask, which bounds the egress set.

The address store is a 64-entry associative table. New entries go into the lowest free slot. Each frame receives its egress mask and a done strobe exactly one cycle after it is presented.

Top module: `fdb_engine`

## Requirements
- R1: After reset, done_o, hit_o, egress_o and full_o are 0. The table is empty, and every VLAN is in shared mode with filter ID 0 and no members. Every port has domain 0 with learning off.
- R2: A request held for one cycle gives done_o=1 on the next cycle, with the result on egress_o and hit_o. In every cycle not following a request, done_o is 0 and egress_o is all zeros.
- R3: Shared-learning VLANs (mode bit 0) key entries by {filter ID, MAC}. An address learned on one such VLAN is found from any other shared VLAN with the same filter ID, whatever the domain of the ingress port.
- R4: Independent-learning VLANs (mode bit 1) key entries by {VID, MAC, domain}. One {VID, MAC} pair learned on two ports with different domains resolves, for each domain, to the port that taught it.
- R5: A frame from a port with learning on creates an entry that maps its source key to the ingress port when no entry matches. A port with learning off creates none.
- R6: When the source key already exists for another port, the entry is moved to the ingress port.
- R7: Frames from the CPU port (port 10) are learned under the tag domain when the tag enable bit is 1. A CPU frame with learn-disable set learns nothing.
- R8: The destination lookup always uses the configured domain of the ingress port. The tag domain fields never change the egress mask.
- R9: On a lookup hit, the egress mask is the one-hot bit of the stored port ANDed with the effective allowance, and hit_o is 1.
- R10: On a miss, the egress mask is the VLAN member mask ANDed with the effective allowance, and hit_o is 0.
- R11: The effective allowance is all ports when ALLOW is 0, when the allowance mask is all zeros, or when it is all ones. Otherwise it is the allowance mask.
- R12: The egress bit of the ingress port is always 0.
- R13: The table holds at most 64 entries. Once all are used, full_o is 1 and stays 1 until reset, and a source miss learns nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vcfg_we | input | 1 | Write one VLAN table row |
| vcfg_vid | input | 4 | VLAN row selected for writing |
| vcfg_indep | input | 1 | Learning mode: 0 shared, 1 independent |
| vcfg_fid | input | 2 | Filter ID of the VLAN |
| vcfg_members | input | 11 | Member ports of the VLAN |
| pcfg_we | input | 1 | Write one port table row |
| pcfg_port | input | 4 | Port row selected for writing |
| pcfg_dom | input | 3 | Learning-domain ID of the port |
| pcfg_learn | input | 1 | Learning enable of the port |
| req_valid | input | 1 | Frame present this cycle |
| req_vid | input | 4 | VID of the frame |
| req_smac | input | 48 | Source MAC |
| req_dmac | input | 48 | Destination MAC |
| req_port | input | 4 | Ingress port |
| tag_dom_en | input | 1 | Tag domain override enable (CPU frames) |
| tag_dom | input | 3 | Tag learning-domain ID |
| tag_learn_dis | input | 1 | Tag learn-disable |
| tag_allow | input | 1 | Allowance mask in force |
| tag_allow_mask | input | 11 | Allowance port mask |
| done_o | output | 1 | Result valid strobe |
| egress_o | output | 11 | Egress port mask |
| hit_o | output | 1 | Destination lookup hit |
| full_o | output | 1 | All table entries in use |

## Verification
Egress mask, hit flag and done strobe are all due one clock edge after the request cycle. Learning and station moves take effect at that same edge, so a frame presented in the very next cycle already sees them. The bench drives each frame on a falling edge and compares the outputs on the following falling edge. It computes the expected result from the table contents before that frame, then applies the frame's learning to its model. full_o is compared right after each update of the model, and done_o dropping is checked in an idle cycle after a request.

// File: rtl/fdb_pkg.sv
package fdb_pkg;
    localparam int MAC_W = 48;
    localparam int DOM_W = 3;

    typedef enum logic {
        VM_SHARED = 1'b0,
        VM_INDEP  = 1'b1
    } vmode_e;
endpackage

// File: rtl/fdb_cfg.sv
// Per-VLAN and per-port configuration tables with combinational read.
module fdb_cfg #(
    parameter int NUM_PORTS = 11,
    parameter int VID_W     = 4,
    parameter int FID_W     = 2,
    parameter int PORT_W    = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          vcfg_we,
    input  logic [VID_W-1:0]              vcfg_vid,
    input  logic                          vcfg_indep,
    input  logic [FID_W-1:0]              vcfg_fid,
    input  logic [NUM_PORTS-1:0]          vcfg_members,
    input  logic                          pcfg_we,
    input  logic [PORT_W-1:0]             pcfg_port,
    input  logic [fdb_pkg::DOM_W-1:0]     pcfg_dom,
    input  logic                          pcfg_learn,
    input  logic [VID_W-1:0]              rd_vid,
    input  logic [PORT_W-1:0]             rd_port,
    output fdb_pkg::vmode_e               rd_mode,
    output logic [FID_W-1:0]              rd_fid,
    output logic [NUM_PORTS-1:0]          rd_members,
    output logic [fdb_pkg::DOM_W-1:0]     rd_dom,
    output logic                          rd_learn
);
    import fdb_pkg::*;
    localparam int NUM_VLANS = 1 << VID_W;

    typedef struct packed {
        logic [NUM_VLANS-1:0]                indep;
        logic [NUM_VLANS-1:0][FID_W-1:0]     fid;
        logic [NUM_VLANS-1:0][NUM_PORTS-1:0] members;
        logic [NUM_PORTS-1:0][DOM_W-1:0]     dom;
        logic [NUM_PORTS-1:0]                learn;
    } cfg_t;

    cfg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (vcfg_we) begin
            st_d.indep[vcfg_vid]   = vcfg_indep;
            st_d.fid[vcfg_vid]     = vcfg_fid;
            st_d.members[vcfg_vid] = vcfg_members;
        end
        if (pcfg_we) begin
            st_d.dom[pcfg_port]   = pcfg_dom;
            st_d.learn[pcfg_port] = pcfg_learn;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_mode    = st_q.indep[rd_vid] ? VM_INDEP : VM_SHARED;
    assign rd_fid     = st_q.fid[rd_vid];
    assign rd_members = st_q.members[rd_vid];
    assign rd_dom     = st_q.dom[rd_port];
    assign rd_learn   = st_q.learn[rd_port];
endmodule

// File: rtl/fdb_cam.sv
// Associative address table: two parallel searches, lowest-free-slot allocation.
module fdb_cam #(
    parameter int DEPTH  = 64,
    parameter int KEY_W  = 56,
    parameter int PORT_W = 4,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [KEY_W-1:0]  src_key,
    input  logic [KEY_W-1:0]  dst_key,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [KEY_W-1:0]  wr_key,
    input  logic [PORT_W-1:0] wr_port,
    output logic              src_hit,
    output logic [IDX_W-1:0]  src_idx,
    output logic [PORT_W-1:0] src_port,
    output logic              dst_hit,
    output logic [PORT_W-1:0] dst_port,
    output logic [IDX_W-1:0]  free_idx,
    output logic              full
);
    typedef struct packed {
        logic [DEPTH-1:0]             valid;
        logic [DEPTH-1:0][KEY_W-1:0]  key;
        logic [DEPTH-1:0][PORT_W-1:0] port;
    } tbl_t;

    tbl_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        src_hit  = 1'b0;
        src_idx  = '0;
        src_port = '0;
        dst_hit  = 1'b0;
        dst_port = '0;
        free_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (st_q.valid[i] && st_q.key[i] == src_key) begin
                src_hit  = 1'b1;
                src_idx  = IDX_W'(i);
                src_port = st_q.port[i];
            end
            if (st_q.valid[i] && st_q.key[i] == dst_key) begin
                dst_hit  = 1'b1;
                dst_port = st_q.port[i];
            end
            if (!st_q.valid[i]) free_idx = IDX_W'(i);
        end
        if (wr_en) begin
            st_d.valid[wr_idx] = 1'b1;
            st_d.key[wr_idx]   = wr_key;
            st_d.port[wr_idx]  = wr_port;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign full = &st_q.valid;
endmodule

// File: rtl/fdb_engine.sv
// Top: key formation, learning decision, egress computation.
module fdb_engine #(
    parameter int NUM_PORTS = 11,
    parameter int DEPTH     = 64,
    parameter int VID_W     = 4,
    parameter int FID_W     = 2,
    parameter int CPU_PORT  = NUM_PORTS - 1,
    localparam int PORT_W   = $clog2(NUM_PORTS),
    localparam int DOM_W    = fdb_pkg::DOM_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 vcfg_we,
    input  logic [VID_W-1:0]     vcfg_vid,
    input  logic                 vcfg_indep,
    input  logic [FID_W-1:0]     vcfg_fid,
    input  logic [NUM_PORTS-1:0] vcfg_members,
    input  logic                 pcfg_we,
    input  logic [PORT_W-1:0]    pcfg_port,
    input  logic [DOM_W-1:0]     pcfg_dom,
    input  logic                 pcfg_learn,
    input  logic                 req_valid,
    input  logic [VID_W-1:0]     req_vid,
    input  logic [47:0]          req_smac,
    input  logic [47:0]          req_dmac,
    input  logic [PORT_W-1:0]    req_port,
    input  logic                 tag_dom_en,
    input  logic [DOM_W-1:0]     tag_dom,
    input  logic                 tag_learn_dis,
    input  logic                 tag_allow,
    input  logic [NUM_PORTS-1:0] tag_allow_mask,
    output logic                 done_o,
    output logic [NUM_PORTS-1:0] egress_o,
    output logic                 hit_o,
    output logic                 full_o
);
    import fdb_pkg::*;
    localparam int ID_W  = (VID_W > FID_W) ? VID_W : FID_W;
    localparam int KEY_W = 1 + ID_W + MAC_W + DOM_W;
    localparam int IDX_W = $clog2(DEPTH);

    typedef struct packed {
        logic                 done;
        logic                 hit;
        logic [NUM_PORTS-1:0] egress;
    } eng_t;

    vmode_e               vl_mode;
    logic [FID_W-1:0]     vl_fid;
    logic [NUM_PORTS-1:0] vl_members;
    logic [DOM_W-1:0]     pt_dom;
    logic                 pt_learn;

    fdb_cfg #(.NUM_PORTS(NUM_PORTS), .VID_W(VID_W), .FID_W(FID_W), .PORT_W(PORT_W)) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .vcfg_we(vcfg_we), .vcfg_vid(vcfg_vid), .vcfg_indep(vcfg_indep),
        .vcfg_fid(vcfg_fid), .vcfg_members(vcfg_members),
        .pcfg_we(pcfg_we), .pcfg_port(pcfg_port), .pcfg_dom(pcfg_dom), .pcfg_learn(pcfg_learn),
        .rd_vid(req_vid), .rd_port(req_port),
        .rd_mode(vl_mode), .rd_fid(vl_fid), .rd_members(vl_members),
        .rd_dom(pt_dom), .rd_learn(pt_learn)
    );

    logic                 is_cpu;
    logic [DOM_W-1:0]     src_dom;
    logic [ID_W-1:0]      key_id;
    logic [KEY_W-1:0]     src_key, dst_key;
    logic                 src_hit, dst_hit, tbl_full, learn_ok, wr_en;
    logic [IDX_W-1:0]     src_idx, free_idx, wr_idx;
    logic [PORT_W-1:0]    src_port, dst_port;
    logic [NUM_PORTS-1:0] allow_eff, in_bit;

    always_comb begin
        is_cpu  = (req_port == PORT_W'(CPU_PORT));
        src_dom = (is_cpu && tag_dom_en) ? tag_dom : pt_dom;
        key_id  = (vl_mode == VM_INDEP) ? ID_W'(req_vid) : ID_W'(vl_fid);
        if (vl_mode == VM_INDEP) begin
            src_key = {1'b1, key_id, req_smac, src_dom};
            dst_key = {1'b1, key_id, req_dmac, pt_dom};
        end else begin
            src_key = {1'b0, key_id, req_smac, {DOM_W{1'b0}}};
            dst_key = {1'b0, key_id, req_dmac, {DOM_W{1'b0}}};
        end
    end

    fdb_cam #(.DEPTH(DEPTH), .KEY_W(KEY_W), .PORT_W(PORT_W)) u_cam (
        .clk(clk), .rst_n(rst_n),
        .src_key(src_key), .dst_key(dst_key),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_key(src_key), .wr_port(req_port),
        .src_hit(src_hit), .src_idx(src_idx), .src_port(src_port),
        .dst_hit(dst_hit), .dst_port(dst_port),
        .free_idx(free_idx), .full(tbl_full)
    );

    // learning: new entry on miss when room, re-point on station move
    always_comb begin
        learn_ok = req_valid && pt_learn && !(is_cpu && tag_learn_dis);
        wr_en    = learn_ok && (src_hit ? (src_port != req_port) : !tbl_full);
        wr_idx   = src_hit ? src_idx : free_idx;
    end

    eng_t st_d, st_q;

    always_comb begin
        in_bit    = NUM_PORTS'(1) << req_port;
        allow_eff = (!tag_allow || tag_allow_mask == '0 || &tag_allow_mask)
                    ? '1 : tag_allow_mask;
        st_d      = '0;
        if (req_valid) begin
            st_d.done   = 1'b1;
            st_d.hit    = dst_hit;
            st_d.egress = (dst_hit ? (NUM_PORTS'(1) << dst_port) : vl_members)
                          & allow_eff & ~in_bit;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done_o   = st_q.done;
    assign hit_o    = st_q.hit;
    assign egress_o = st_q.egress;
    assign full_o   = tbl_full;
endmodule

// File: rtl/fdb_engine_chk.sv
module fdb_engine_chk #(
    parameter int NUM_PORTS = 11,
    parameter int PORT_W    = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic [PORT_W-1:0]    req_port,
    input logic                 tag_allow,
    input logic [NUM_PORTS-1:0] tag_allow_mask,
    input logic                 done_o,
    input logic [NUM_PORTS-1:0] egress_o,
    input logic                 full_o
);
    a_r2_done_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> done_o);
    a_r2_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !done_o);
    a_r2_idle_mask_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> egress_o == '0);
    a_r12_no_hairpin: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (egress_o & (NUM_PORTS'(1) << $past(req_port))) == '0);
    a_r11_within_allowance: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && $past(tag_allow) && $past(tag_allow_mask) != '0 && !(&$past(tag_allow_mask)))
        |-> (egress_o & ~$past(tag_allow_mask)) == '0);
    a_r13_full_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(full_o));
endmodule

bind fdb_engine fdb_engine_chk #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_port(req_port),
    .tag_allow(tag_allow), .tag_allow_mask(tag_allow_mask),
    .done_o(done_o), .egress_o(egress_o), .full_o(full_o)
);

// File: tb/fdb_engine_tb_top.sv
`timescale 1ns/1ps
module fdb_engine_tb_top;
    localparam int NP  = 11;
    localparam int CPU = 10;
    localparam int KW  = 1 + 4 + 48 + 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic vcfg_we = 0, vcfg_indep = 0, pcfg_we = 0, pcfg_learn = 0;
    logic [3:0] vcfg_vid = 0, pcfg_port = 0, req_vid = 0, req_port = 0;
    logic [1:0] vcfg_fid = 0;
    logic [NP-1:0] vcfg_members = 0, tag_allow_mask = 0;
    logic [2:0] pcfg_dom = 0, tag_dom = 0;
    logic req_valid = 0, tag_dom_en = 0, tag_learn_dis = 0, tag_allow = 0;
    logic [47:0] req_smac = 0, req_dmac = 0;
    logic done_o, hit_o, full_o;
    logic [NP-1:0] egress_o;

    fdb_engine dut_i (.*);

    int tests = 0, fails = 0;

    // reference state
    bit          m_indep[16];
    logic [1:0]  m_fid[16];
    logic [NP-1:0] m_mem[16];
    logic [2:0]  m_dom[NP];
    bit          m_learn[NP];
    bit          e_val[64];
    logic [KW-1:0] e_key[64];
    int          e_port[64];
    int          e_cnt;

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic void model_clear();
        for (int i = 0; i < 16; i++) begin m_indep[i] = 0; m_fid[i] = 0; m_mem[i] = 0; end
        for (int i = 0; i < NP; i++) begin m_dom[i] = 0; m_learn[i] = 0; end
        for (int i = 0; i < 64; i++) e_val[i] = 0;
        e_cnt = 0;
    endfunction

    function automatic logic [KW-1:0] mkey(logic [3:0] vid, logic [47:0] mac, logic [2:0] dom);
        if (m_indep[vid]) return {1'b1, vid, mac, dom};
        return {1'b0, 2'b00, m_fid[vid], mac, 3'b000};
    endfunction

    function automatic int mfind(logic [KW-1:0] k);
        for (int i = 0; i < 64; i++) if (e_val[i] && e_key[i] == k) return i;
        return -1;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        model_clear();
    endtask

    task automatic cfg_vlan(int vid, bit indep, int fid, logic [NP-1:0] mem);
        vcfg_we = 1; vcfg_vid = 4'(vid); vcfg_indep = indep; vcfg_fid = 2'(fid); vcfg_members = mem;
        @(negedge clk);
        vcfg_we = 0;
        m_indep[vid] = indep; m_fid[vid] = 2'(fid); m_mem[vid] = mem;
    endtask

    task automatic cfg_port(int p, int dom, bit learn);
        pcfg_we = 1; pcfg_port = 4'(p); pcfg_dom = 3'(dom); pcfg_learn = learn;
        @(negedge clk);
        pcfg_we = 0;
        m_dom[p] = 3'(dom); m_learn[p] = learn;
    endtask

    // drive at a falling edge, compare one falling edge later
    task automatic send(string req, int vid, logic [47:0] smac, logic [47:0] dmac, int port,
                        bit den, int tdom, bit ldis, bit allow, logic [NP-1:0] amask);
        logic [NP-1:0] aeff, exp_e;
        int d, s, lp;
        bit lok;
        logic [KW-1:0] sk;
        req_valid = 1; req_vid = 4'(vid); req_smac = smac; req_dmac = dmac; req_port = 4'(port);
        tag_dom_en = den; tag_dom = 3'(tdom); tag_learn_dis = ldis; tag_allow = allow;
        tag_allow_mask = amask;
        aeff = (!allow || amask == '0 || &amask) ? '1 : amask;
        d = mfind(mkey(4'(vid), dmac, m_dom[port]));
        exp_e = ((d >= 0) ? (NP'(1) << e_port[d]) : m_mem[vid]) & aeff & ~(NP'(1) << port);
        @(posedge clk);
        @(negedge clk);
        req_valid = 0;
        chk(done_o === 1'b1, {req, " done"}, 64'(done_o), 64'd1);
        chk(egress_o === exp_e, {req, " egress"}, 64'(egress_o), 64'(exp_e));
        chk(hit_o === (d >= 0), {req, " hit"}, 64'(hit_o), 64'(d >= 0));
        lok = m_learn[port] && !(port == CPU && ldis);
        sk = mkey(4'(vid), smac, (port == CPU && den) ? 3'(tdom) : m_dom[port]);
        if (lok) begin
            s = mfind(sk);
            if (s >= 0) e_port[s] = port;
            else if (e_cnt < 64) begin
                lp = 0;
                while (e_val[lp]) lp++;
                e_val[lp] = 1; e_key[lp] = sk; e_port[lp] = port; e_cnt++;
            end
        end
        chk(full_o === (e_cnt == 64), {req, " R13 full flag"}, 64'(full_o), 64'(e_cnt == 64));
    endtask

    localparam logic [47:0] MA = 48'h0200_0000_00A1, MB = 48'h0200_0000_00B2,
                            MC = 48'h0200_0000_00C3, MD = 48'h0200_0000_00D4,
                            ME = 48'h0200_0000_00E5, MX = 48'h0200_0000_0FFF;
    localparam logic [NP-1:0] ALL = '1;

    initial begin
        #(5ns * 150000);
        fails++;
        $display("FAIL watchdog R2: actual hung expected finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20211005));
        model_clear();
        do_reset();
        // R1 reset state
        chk(done_o === 1'b0, "R1 done", 64'(done_o), 0);
        chk(egress_o === '0, "R1 egress", 64'(egress_o), 0);
        chk(full_o === 1'b0, "R1 full", 64'(full_o), 0);
        send("R1 empty vlan", 2, MA, MB, 0, 0, 0, 0, 0, '0);

        for (int p = 0; p < NP; p++) cfg_port(p, (p % 2 == 1) ? 1 : 2, p != 7);
        cfg_port(CPU, 0, 1);
        cfg_vlan(3, 1, 0, ALL);
        cfg_vlan(5, 0, 1, ALL);
        cfg_vlan(6, 0, 1, ALL);

        // R4 independent learning per domain
        send("R4 learn p1", 3, MA, MX, 1, 0, 0, 0, 0, '0);
        send("R4 learn p2", 3, MA, MX, 2, 0, 0, 0, 0, '0);
        send("R4 lookup dom1", 3, MC, MA, 3, 0, 0, 0, 0, '0);
        send("R4 lookup dom2", 3, MC, MA, 4, 0, 0, 0, 0, '0);
        // R2 done falls when idle
        @(negedge clk);
        chk(done_o === 1'b0, "R2 done drops", 64'(done_o), 0);
        chk(egress_o === '0, "R2 idle egress", 64'(egress_o), 0);
        // R3 shared key across VLANs with the same filter ID
        send("R3 learn", 5, MB, MX, 1, 0, 0, 0, 0, '0);
        send("R3 lookup other vlan", 6, MC, MB, 4, 0, 0, 0, 0, '0);
        // R6 station move
        send("R6 move", 5, MB, MX, 5, 0, 0, 0, 0, '0);
        send("R6 lookup", 6, MC, MB, 3, 0, 0, 0, 0, '0);
        // R5 learning disabled port
        send("R5 no learn", 3, MC, MX, 7, 0, 0, 0, 0, '0);
        send("R5 lookup", 3, ME, MC, 1, 0, 0, 0, 0, '0);
        // R7 CPU learning under tag domain
        send("R7 cpu learn", 3, MD, MX, CPU, 1, 2, 0, 0, '0);
        send("R7 lookup dom2", 3, MC, MD, 2, 0, 0, 0, 0, '0);
        send("R7 lookup dom1", 3, MC, MD, 1, 0, 0, 0, 0, '0);
        send("R7 learn-dis", 3, ME, MX, CPU, 1, 2, 1, 0, '0);
        send("R7 lookup dis", 3, MC, ME, 2, 0, 0, 0, 0, '0);
        // R8 tag domain does not steer the lookup
        send("R8 tag dom", 3, MX, MA, CPU, 1, 2, 1, 1, '0);
        // R9 hit with allowance
        cfg_port(CPU, 1, 1);
        send("R9 hit allowed", 3, MX, MA, CPU, 0, 0, 1, 1, 11'h003);
        send("R9 hit masked", 3, MX, MA, CPU, 0, 0, 1, 1, 11'h00C);
        // R10 miss flood within allowance
        send("R10 flood", 3, MX, 48'h0200_0000_7777, CPU, 0, 0, 1, 1, 11'h00F);
        // R11 no-restriction encodings
        send("R11 zero mask", 3, MX, 48'h0200_0000_7777, CPU, 0, 0, 1, 1, '0);
        send("R11 ones mask", 3, MX, 48'h0200_0000_7777, CPU, 0, 0, 1, 1, ALL);
        send("R11 allow off", 3, MX, 48'h0200_0000_7777, CPU, 0, 0, 1, 0, 11'h001);
        // R12 hairpin suppressed
        send("R12 hairpin", 3, MC, MA, 1, 0, 0, 0, 0, '0);

        // random mix
        for (int v = 0; v < 4; v++) cfg_vlan(v + 8, $urandom % 2, $urandom % 4, NP'($urandom));
        for (int p = 0; p < NP; p++) cfg_port(p, $urandom % 8, ($urandom % 4) != 0);
        for (int n = 0; n < 300; n++) begin
            int p;
            p = $urandom % NP;
            send("R9 R10 random", 8 + $urandom % 4, 48'h0200_0000_0100 + 48'($urandom % 6),
                 48'h0200_0000_0100 + 48'($urandom % 7), p, $urandom % 2, $urandom % 8,
                 ($urandom % 4) == 0, $urandom % 2, NP'($urandom));
        end

        // R13 fill the table
        do_reset();
        chk(full_o === 1'b0, "R1 full after reset", 64'(full_o), 0);
        cfg_vlan(1, 0, 0, ALL);
        cfg_port(0, 0, 1);
        for (int i = 0; i < 70; i++)
            send("R13 fill", 1, 48'h0300_0000_0000 + 48'(i), MX, 0, 0, 0, 0, 0, '0);
        send("R13 dropped miss", 1, MX, 48'h0300_0000_0000 + 48'd66, 1, 0, 0, 0, 0, '0);
        send("R13 stored hit", 1, MX, 48'h0300_0000_0000 + 48'd3, 1, 0, 0, 0, 0, '0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule